// File: doc/BRIEF.md
# Multi-Way Sequential Stream Prefetch Buffer

This block sits beside a cache and intercepts its misses before they reach the next memory level. It holds several independent prefetch queues, called streams. Each stream is a short FIFO of entries. An entry carries a line address tag, a ready flag and one line of data. Only the oldest entry of each stream, its head, is compared with an incoming miss.

On a head match, the line is returned from the stream and popped. The stream then fetches one more sequential line at its tail. When no head matches, the block reports a miss. It then takes the least recently used stream, empties it, and refills it with the lines that follow the missed line. Prefetched lines stay in the streams and never go into the cache until a miss asks for them. This lets several interleaved sequential access patterns be followed at once.

The lookup side and the fetch side are two separate state machines. The lookup machine has the states L_IDLE, L_LOOK, L_HOLD and L_RESP, with these transitions:
- L_IDLE to L_LOOK when a miss is accepted.
- L_LOOK to L_HOLD when a head matches but its data has not arrived.
- L_LOOK to L_RESP in every other case.
- L_HOLD to L_RESP when the awaited data arrives.
- L_RESP back to L_IDLE after one cycle.

The fetch machine has the states F_IDLE, F_REQ and F_WAIT, with these transitions:
- F_IDLE to F_REQ when any stream has a free entry.
- F_REQ to F_WAIT when the lower level accepts the request.
- F_WAIT back to F_IDLE when the line returns.

Top module: `sbuf_stream_set`

## Requirements
- R1: After reset, miss_ready is 1, and resp_valid and fetch_req_valid are 0. No fetch is requested until the first miss has been looked up.
- R2: A lookup that is answered without waiting raises resp_valid for exactly one cycle. It rises on the second falling clock edge after the edge that accepted the miss. miss_ready is low while resp_valid is high.
- R3: A miss that matches no stream head is answered with resp_hit = 0. The reallocated stream then requests lines L+1, L+2, up to L+DEPTH, in ascending order, where L is the missed line.
- R4: A miss whose line equals a stream head that holds its data is answered with resp_hit = 1 and that line's data. The stream then requests exactly one new line, equal to the old head plus DEPTH.
- R5: Only heads are compared. A line held deeper in a stream, but not at its head, is treated as a miss, and a stream is reallocated for it.
- R6: A miss that matches a head whose fetch has been issued but not yet returned waits for the fill. It then answers resp_hit = 1 with that data, and no second request for that line is made.
- R7: The stream that is reallocated is the one least recently allocated or hit. After reset, streams are taken in the order NUM_BUF-1 down to 0.
- R8: At most one fetch is outstanding. fetch_req_valid stays low from an accepted request until fill_valid has returned its line.
- R9: While fetch_req_valid is high and fetch_req_ready is low, the request stays asserted and fetch_req_line stays unchanged.
- R10: When several streams need lines, requests are granted in round-robin order. No stream receives two grants in a row while another stream is waiting.
- R11: If a stream is reallocated while a fetch for it is in flight, the returning line is discarded. The stream's later contents are the new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Cache miss presented for lookup |
| miss_line | input | ADDR_W | Line address of the miss |
| miss_ready | output | 1 | Lookup side can accept a miss |
| resp_valid | output | 1 | Lookup answer valid for one cycle |
| resp_hit | output | 1 | 1 when the line was served from a stream |
| resp_data | output | DATA_W | Line data on a hit, zero on a miss |
| fetch_req_valid | output | 1 | Line fetch request to the lower level |
| fetch_req_line | output | ADDR_W | Line address being fetched |
| fetch_req_ready | input | 1 | Lower level accepts the request |
| fill_valid | input | 1 | Requested line returns |
| fill_data | input | DATA_W | Data of the returning line |

## Verification
A wrong stream head, a wrong ready flag or a wrong LRU ordering shows up at the ports on the very next lookup that touches the affected stream. It appears as a flipped resp_hit, wrong resp_data, or a response that waits when it should not. A wrong tail address or a wrong refill start shows up as soon as the fetch side issues requests. So every lookup is followed by a check of the exact sequence of requested lines once the streams have filled. This catches a misplaced refill within one lookup of its cause. In-flight fetches crossing a reallocation, and hits on lines still being fetched, are driven on purpose with long fill latencies. This exposes duplicate requests and stale fills.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        L_IDLE,
        L_LOOK,
        L_HOLD,
        L_RESP
    } look_state_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_WAIT
    } fetch_state_e;

endpackage

// File: rtl/sbuf_lane.sv
module sbuf_lane #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_line_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              fill_i,
    input  logic [PTR_W-1:0]  fill_slot_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              need_o,
    output logic              head_valid_o,
    output logic [ADDR_W-1:0] head_tag_o,
    output logic              head_avail_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic [ADDR_W-1:0] next_line_o,
    output logic [PTR_W-1:0]  wr_slot_o
);

    logic              live_q;
    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  avail_q;
    logic [ADDR_W-1:0] next_q;
    logic [ADDR_W-1:0] tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // control state: flush wins over everything else
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q  <= 1'b0;
            rd_q    <= '0;
            wr_q    <= '0;
            cnt_q   <= '0;
            avail_q <= '0;
            next_q  <= '0;
        end else if (flush_i) begin
            live_q  <= 1'b1;
            rd_q    <= '0;
            wr_q    <= '0;
            cnt_q   <= '0;
            avail_q <= '0;
            next_q  <= flush_line_i + 1'b1;
        end else begin
            if (push_i) begin
                avail_q[wr_q] <= 1'b0;
                wr_q          <= ring_inc(wr_q);
                next_q        <= next_q + 1'b1;
            end
            if (pop_i) begin
                rd_q <= ring_inc(rd_q);
            end
            if (fill_i) begin
                avail_q[fill_slot_i] <= 1'b1;
            end
            unique case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (!flush_i && push_i) begin
            tag_q[wr_q] <= next_q;
        end
        if (!flush_i && fill_i) begin
            data_q[fill_slot_i] <= fill_data_i;
        end
    end

    always_comb begin
        head_valid_o = live_q && (cnt_q != '0);
        head_tag_o   = tag_q[rd_q];
        head_avail_o = head_valid_o && avail_q[rd_q];
        head_data_o  = data_q[rd_q];
        need_o       = live_q && (cnt_q < CNT_W'(DEPTH));
        next_line_o  = next_q;
        wr_slot_o    = wr_q;
    end

endmodule

// File: rtl/sbuf_lru.sv
module sbuf_lru #(
    parameter int N = 4,
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch_i,
    input  logic [ID_W-1:0] touch_id_i,
    output logic [ID_W-1:0] lru_id_o
);

    logic [ID_W-1:0] age_q [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_age
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q[g] <= ID_W'(g);
                end else if (touch_i) begin
                    if (touch_id_i == ID_W'(g)) begin
                        age_q[g] <= '0;
                    end else if (age_q[g] < age_q[touch_id_i]) begin
                        age_q[g] <= age_q[g] + 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        lru_id_o = '0;
        for (int i = 0; i < N; i++) begin
            if (age_q[i] == ID_W'(N - 1)) begin
                lru_id_o = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/sbuf_rr_arb.sv
module sbuf_rr_arb #(
    parameter int N = 4,
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_i,
    input  logic            take_i,
    output logic            any_o,
    output logic [ID_W-1:0] grant_o
);

    logic [ID_W-1:0] ptr_q;

    always_comb begin
        any_o   = 1'b0;
        grant_o = '0;
        for (int off = 0; off < N; off++) begin
            int unsigned idx;
            idx = (int'(ptr_q) + off) % N;
            if (!any_o && req_i[idx]) begin
                any_o   = 1'b1;
                grant_o = ID_W'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take_i && any_o) begin
            ptr_q <= (grant_o == ID_W'(N - 1)) ? '0 : grant_o + 1'b1;
        end
    end

endmodule

// File: rtl/sbuf_stream_set.sv
module sbuf_stream_set
    import sbuf_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_line,
    output logic              miss_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_data,
    output logic              fetch_req_valid,
    output logic [ADDR_W-1:0] fetch_req_line,
    input  logic              fetch_req_ready,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    localparam int ID_W  = $clog2(NUM_BUF);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    look_state_e  ls_q, ls_d;
    fetch_state_e fs_q, fs_d;

    logic [ADDR_W-1:0] look_line_q;
    logic [ID_W-1:0]   hold_id_q;
    logic              resp_hit_q;
    logic [DATA_W-1:0] resp_data_q;

    logic [ADDR_W-1:0] f_line_q;
    logic [ID_W-1:0]   f_buf_q;
    logic [PTR_W-1:0]  f_slot_q;
    logic              f_stale_q;

    logic [NUM_BUF-1:0] need, head_valid, head_avail;
    logic [NUM_BUF-1:0] flush, push, pop, fill;
    logic [ADDR_W-1:0]  head_tag  [NUM_BUF];
    logic [ADDR_W-1:0]  next_line [NUM_BUF];
    logic [DATA_W-1:0]  head_data [NUM_BUF];
    logic [PTR_W-1:0]   wr_slot   [NUM_BUF];

    logic              match_any;
    logic [ID_W-1:0]   match_id;
    logic              hit_ready;
    logic [ID_W-1:0]   lru_id;
    logic              touch;
    logic [ID_W-1:0]   touch_id;
    logic              arb_any;
    logic [ID_W-1:0]   arb_id;
    logic              arb_take;

    // ---------------- stream lanes ----------------
    generate
        for (genvar g = 0; g < NUM_BUF; g++) begin : g_lane
            sbuf_lane #(
                .DEPTH (DEPTH),
                .ADDR_W(ADDR_W),
                .DATA_W(DATA_W)
            ) u_lane (
                .clk         (clk),
                .rst_n       (rst_n),
                .flush_i     (flush[g]),
                .flush_line_i(look_line_q),
                .push_i      (push[g]),
                .pop_i       (pop[g]),
                .fill_i      (fill[g]),
                .fill_slot_i (f_slot_q),
                .fill_data_i (fill_data),
                .need_o      (need[g]),
                .head_valid_o(head_valid[g]),
                .head_tag_o  (head_tag[g]),
                .head_avail_o(head_avail[g]),
                .head_data_o (head_data[g]),
                .next_line_o (next_line[g]),
                .wr_slot_o   (wr_slot[g])
            );
        end
    endgenerate

    sbuf_lru #(.N(NUM_BUF)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_i   (touch),
        .touch_id_i(touch_id),
        .lru_id_o  (lru_id)
    );

    sbuf_rr_arb #(.N(NUM_BUF)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (need),
        .take_i (arb_take),
        .any_o  (arb_any),
        .grant_o(arb_id)
    );

    // ---------------- head comparison ----------------
    always_comb begin
        match_any = 1'b0;
        match_id  = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (!match_any && head_valid[i] && (head_tag[i] == look_line_q)) begin
                match_any = 1'b1;
                match_id  = ID_W'(i);
            end
        end
        hit_ready = match_any && head_avail[match_id];
    end

    // ---------------- lane control ----------------
    always_comb begin
        for (int i = 0; i < NUM_BUF; i++) begin
            flush[i] = (ls_q == L_LOOK) && !match_any && (lru_id == ID_W'(i));
            pop[i]   = ((ls_q == L_LOOK) && hit_ready && (match_id == ID_W'(i)))
                    || ((ls_q == L_HOLD) && (hold_id_q == ID_W'(i)) && head_avail[i]);
            push[i]  = (fs_q == F_REQ) && fetch_req_ready && !f_stale_q
                    && (f_buf_q == ID_W'(i));
            fill[i]  = (fs_q == F_WAIT) && fill_valid && !f_stale_q
                    && (f_buf_q == ID_W'(i));
        end
        touch    = (ls_q == L_LOOK);
        touch_id = match_any ? match_id : lru_id;
        arb_take = (fs_q == F_IDLE) && arb_any;
    end

    // ---------------- state registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_q <= L_IDLE;
            fs_q <= F_IDLE;
        end else begin
            ls_q <= ls_d;
            fs_q <= fs_d;
        end
    end

    // ---------------- lookup next state ----------------
    always_comb begin
        ls_d = ls_q;
        unique case (ls_q)
            L_IDLE:  if (miss_valid) ls_d = L_LOOK;
            L_LOOK:  ls_d = (match_any && !hit_ready) ? L_HOLD : L_RESP;
            L_HOLD:  if (head_avail[hold_id_q]) ls_d = L_RESP;
            L_RESP:  ls_d = L_IDLE;
            default: ls_d = L_IDLE;
        endcase
    end

    // ---------------- fetch next state ----------------
    always_comb begin
        fs_d = fs_q;
        unique case (fs_q)
            F_IDLE:  if (arb_any) fs_d = F_REQ;
            F_REQ:   if (fetch_req_ready) fs_d = F_WAIT;
            F_WAIT:  if (fill_valid) fs_d = F_IDLE;
            default: fs_d = F_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            look_line_q <= '0;
            hold_id_q   <= '0;
            resp_hit_q  <= 1'b0;
            resp_data_q <= '0;
            f_line_q    <= '0;
            f_buf_q     <= '0;
            f_slot_q    <= '0;
            f_stale_q   <= 1'b0;
        end else begin
            if (ls_q == L_IDLE && miss_valid) begin
                look_line_q <= miss_line;
            end
            if (ls_q == L_LOOK) begin
                hold_id_q   <= match_id;
                resp_hit_q  <= match_any;
                resp_data_q <= hit_ready ? head_data[match_id] : '0;
            end
            if (ls_q == L_HOLD && head_avail[hold_id_q]) begin
                resp_hit_q  <= 1'b1;
                resp_data_q <= head_data[hold_id_q];
            end
            if (arb_take) begin
                f_buf_q   <= arb_id;
                f_line_q  <= next_line[arb_id];
                f_stale_q <= flush[arb_id];
            end else if (fs_q != F_IDLE && flush[f_buf_q]) begin
                f_stale_q <= 1'b1;
            end
            if (fs_q == F_REQ && fetch_req_ready) begin
                f_slot_q <= wr_slot[f_buf_q];
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        miss_ready      = (ls_q == L_IDLE);
        resp_valid      = (ls_q == L_RESP);
        resp_hit        = resp_hit_q;
        resp_data       = resp_data_q;
        fetch_req_valid = (fs_q == F_REQ);
        fetch_req_line  = f_line_q;
    end

endmodule

// File: rtl/sbuf_stream_set_chk.sv
module sbuf_stream_set_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_ready,
    input logic              resp_valid,
    input logic              fetch_req_valid,
    input logic              fetch_req_ready,
    input logic [ADDR_W-1:0] fetch_req_line,
    input logic              fill_valid
);

    logic in_flight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_flight_q <= 1'b0;
        end else if (fetch_req_valid && fetch_req_ready) begin
            in_flight_q <= 1'b1;
        end else if (fill_valid) begin
            in_flight_q <= 1'b0;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_valid && !fetch_req_ready |=> fetch_req_valid && $stable(fetch_req_line)); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight_q |-> !fetch_req_valid); // R8

    AST_FILL_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> in_flight_q); // R8

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R2

    AST_BUSY_WHILE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !miss_ready); // R2

endmodule

bind sbuf_stream_set sbuf_stream_set_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_ready     (miss_ready),
    .resp_valid     (resp_valid),
    .fetch_req_valid(fetch_req_valid),
    .fetch_req_ready(fetch_req_ready),
    .fetch_req_line (fetch_req_line),
    .fill_valid     (fill_valid)
);

// File: tb/sbuf_stream_set_test.sv
module sbuf_stream_set_test;

    localparam int NB = 4;
    localparam int DP = 4;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LOG_N = 2048;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          miss_valid;
    logic [AW-1:0] miss_line;
    logic          miss_ready;
    logic          resp_valid;
    logic          resp_hit;
    logic [DW-1:0] resp_data;
    logic          fetch_req_valid;
    logic [AW-1:0] fetch_req_line;
    logic          fetch_req_ready;
    logic          fill_valid;
    logic [DW-1:0] fill_data;

    always #10 clk = ~clk;

    sbuf_stream_set #(.NUM_BUF(NB), .DEPTH(DP), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_line      (miss_line),
        .miss_ready     (miss_ready),
        .resp_valid     (resp_valid),
        .resp_hit       (resp_hit),
        .resp_data      (resp_data),
        .fetch_req_valid(fetch_req_valid),
        .fetch_req_line (fetch_req_line),
        .fetch_req_ready(fetch_req_ready),
        .fill_valid     (fill_valid),
        .fill_data      (fill_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // lower-level model state
    logic [AW-1:0] req_log [LOG_N];
    int            n_req   = 0;
    int            fill_lat = 1;
    bit            busy    = 1'b0;
    int            viol_r8 = 0;
    int            viol_r9 = 0;
    logic [AW-1:0] rsp_line;

    // stream model
    bit            m_live [NB];
    logic [AW-1:0] m_head [NB];
    int            m_age  [NB];
    int            last_lat;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] l);
        return {l ^ 16'hA5C3, l * 16'd3 + 16'd1};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void m_touch(input int id);
        int ref_age;
        ref_age = m_age[id];
        for (int j = 0; j < NB; j++) begin
            if (j != id && m_age[j] < ref_age) m_age[j]++;
        end
        m_age[id] = 0;
    endfunction

    function automatic int m_lru();
        int v;
        v = 0;
        for (int j = 0; j < NB; j++) if (m_age[j] == NB - 1) v = j;
        return v;
    endfunction

    // lower-level responder: delayed accept, one fill per request
    initial begin
        fetch_req_ready = 1'b0;
        fill_valid      = 1'b0;
        fill_data       = '0;
        forever begin
            @(negedge clk);
            fill_valid = 1'b0;
            if (rst_n === 1'b1 && fetch_req_valid) begin
                busy     = 1'b1;
                rsp_line = fetch_req_line;
                repeat (n_req % 3) begin
                    @(negedge clk);
                    if (!fetch_req_valid || fetch_req_line != rsp_line) viol_r9++;
                end
                fetch_req_ready = 1'b1;
                @(negedge clk);
                fetch_req_ready = 1'b0;
                req_log[n_req % LOG_N] = rsp_line;
                n_req++;
                repeat (fill_lat) begin
                    if (fetch_req_valid) viol_r8++;
                    @(negedge clk);
                end
                if (fetch_req_valid) viol_r8++;
                fill_valid = 1'b1;
                fill_data  = mem_word(rsp_line);
                busy       = 1'b0;
            end
        end
    end

    task automatic quiesce();
        int quiet;
        int guard;
        quiet = 0;
        guard = 0;
        while (quiet < 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (!busy && !fetch_req_valid) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic do_lookup(input logic [AW-1:0] line, input bit quiet_mode,
                             input string req, output bit exp_hit);
        int eid;
        int lat;
        exp_hit = 1'b0;
        eid     = 0;
        for (int i = 0; i < NB; i++) begin
            if (!exp_hit && m_live[i] && m_head[i] == line) begin
                exp_hit = 1'b1;
                eid     = i;
            end
        end
        if (!exp_hit) begin
            eid         = m_lru();
            m_live[eid] = 1'b1;
        end
        m_head[eid] = line + 1'b1;
        m_touch(eid);

        @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = line;
        @(negedge clk);
        miss_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        last_lat = lat;
        chk(resp_hit == exp_hit, req, "hit flag", 64'(resp_hit), 64'(exp_hit));
        if (exp_hit) chk(resp_data == mem_word(line), req, "line data",
                         64'(resp_data), 64'(mem_word(line)));
        if (quiet_mode) chk(lat == 2, "R2", "response latency", 64'(lat), 64'd2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit h;
        int n0;
        int xa, yb, bad;
        logic [AW-1:0] ln;
        void'($urandom(32'd4242));
        rst_n      = 1'b0;
        miss_valid = 1'b0;
        miss_line  = '0;
        for (int i = 0; i < NB; i++) begin
            m_live[i] = 1'b0;
            m_head[i] = '0;
            m_age[i]  = i;
        end
        repeat (4) @(negedge clk);
        chk(miss_ready == 1'b1, "R1", "miss_ready in reset", 64'(miss_ready), 64'd1);
        chk(resp_valid == 1'b0, "R1", "resp_valid in reset", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(fetch_req_valid == 1'b0 && n_req == 0, "R1", "fetch idle before first miss",
            64'(n_req), 64'd0);

        // round-robin between two fresh streams
        fill_lat = 3;
        do_lookup(16'h0100, 1'b1, "R3", h);
        do_lookup(16'h0200, 1'b0, "R3", h);
        quiesce();
        chk(n_req == 2 * DP, "R10", "request count two streams", 64'(n_req), 64'(2 * DP));
        xa = 0; yb = 0; bad = 0;
        for (int k = 0; k < n_req; k++) begin
            if (req_log[k][15:8] == 8'h01) begin
                chk(req_log[k] == 16'h0101 + 16'(xa), "R3", "ascending refill",
                    64'(req_log[k]), 64'(16'h0101 + 16'(xa)));
                xa++;
            end else begin
                yb++;
            end
            if (k + 1 < n_req && yb > 0 && xa < DP && yb < DP
                && req_log[k][15:8] == req_log[k + 1][15:8]) bad++;
        end
        chk(xa == DP && yb == DP, "R10", "grants per stream", 64'(xa), 64'(DP));
        chk(bad == 0, "R10", "back-to-back grant while other waits", 64'(bad), 64'd0);

        // hit on a head still in flight
        fill_lat = 20;
        n0 = n_req;
        do_lookup(16'h0300, 1'b1, "R7", h);
        while (n_req == n0) @(negedge clk);
        do_lookup(16'h0301, 1'b0, "R6", h);
        chk(last_lat > 2, "R6", "waited for fill", 64'(last_lat), 64'd3);
        quiesce();
        xa = 0;
        for (int k = n0; k < n_req; k++) if (req_log[k % LOG_N] == 16'h0301) xa++;
        chk(xa == 1, "R6", "requests for waited line", 64'(xa), 64'd1);

        // reallocation with a fetch in flight
        fill_lat = 25;
        for (int s = 4; s <= 8; s++) do_lookup(AW'(s * 256), 1'b0, "R7", h);
        quiesce();
        do_lookup(16'h0801, 1'b1, "R11", h);
        do_lookup(16'h0401, 1'b1, "R7", h);
        quiesce();

        // constrained random traffic
        for (int it = 0; it < 150; it++) begin
            int sel;
            int mode;
            bit deep;
            logic [AW-1:0] oh;
            fill_lat = int'($urandom % 4);
            sel  = int'($urandom % NB);
            mode = int'($urandom % 4);
            deep = 1'b0;
            if (mode <= 1 && m_live[sel]) begin
                ln = m_head[sel];
            end else if (mode == 2 && m_live[sel]) begin
                ln   = m_head[sel] + AW'(1 + $urandom % (DP - 1));
                deep = 1'b1;
            end else begin
                ln = 16'h1000 + AW'($urandom % 64);
            end
            oh = ln;
            n0 = n_req;
            do_lookup(ln, 1'b1, deep ? "R5" : "R4", h);
            quiesce();
            if (h) begin
                chk(n_req - n0 == 1, "R4", "one tail request", 64'(n_req - n0), 64'd1);
                chk(req_log[n0 % LOG_N] == oh + AW'(DP), "R4", "tail line",
                    64'(req_log[n0 % LOG_N]), 64'(oh + AW'(DP)));
            end else begin
                chk(n_req - n0 == DP, deep ? "R5" : "R3", "refill count",
                    64'(n_req - n0), 64'(DP));
                for (int k = 0; k < DP; k++) begin
                    chk(req_log[(n0 + k) % LOG_N] == oh + AW'(k + 1), "R3", "refill line",
                        64'(req_log[(n0 + k) % LOG_N]), 64'(oh + AW'(k + 1)));
                end
            end
        end

        chk(viol_r8 == 0, "R8", "request while fetch outstanding", 64'(viol_r8), 64'd0);
        chk(viol_r9 == 0, "R9", "request dropped or changed", 64'(viol_r9), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule